// File: doc/BRIEF.md
# Host-Settable Nanosecond Timestamp Unit

This block keeps a 64-bit device time that a host can load and read with short commands. Each command arrives as a one-cycle strobe with a command-set code, a command code, an input length and an 8-byte payload. A load stores the host value and restarts a free-running elapsed counter. A read returns the stored value plus the nanoseconds counted since that load. Until the first load after reset, a read returns zero.

The elapsed counter advances by a fixed number of nanoseconds on every clock cycle. This value is set by a parameter and should equal the clock period in nanoseconds. Every command gets a registered response one cycle after its strobe, made of a return code, an output length and an 8-byte response. An accepted load also raises a one-cycle policy-change flag. The surrounding mailbox transport, doorbells and interrupts live outside this block.

Top module: `tstamp_unit`

## Requirements
- R1: After reset, rsp_valid and policy_chg are 0. A read issued before any accepted load returns code 0, length 8 and payload 0.
- R2: rsp_valid is high in exactly the cycle after each cycle in which cmd_valid is high, and low otherwise.
- R3: A load (command set 0x03, command 0x01, cmd_len 8) returns code 0, length 0 and payload 0. policy_chg is high for that single response cycle.
- R4: A read (command set 0x03, command 0x00) returns code 0 and length 8. Its payload is H + STEP_NS*(n-1), where H is the last loaded value and n is the number of clock edges from the load strobe to the read strobe. Payload byte i sits in bits 8i+7:8i (little-endian), both for input and for output.
- R5: The elapsed count and the sum both wrap modulo 2^64.
- R6: Any other command-set or command code returns code 0x15, length 0 and payload 0. It leaves the stored time unchanged and does not raise policy_chg.
- R7: A load with cmd_len other than 8 returns code 0x02, length 0 and payload 0. It leaves the stored time unchanged and does not raise policy_chg.
- R8: A read ignores cmd_len and cmd_payload.
- R9: A new load replaces the stored value and restarts the elapsed count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_set | input | 8 | Command-set code |
| cmd_op | input | 8 | Command code within the set |
| cmd_len | input | 16 | Input payload length in bytes |
| cmd_payload | input | 64 | Input payload, little-endian |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 16 | Return code: 0 ok, 0x02 invalid input, 0x15 unsupported |
| rsp_len | output | 16 | Output payload length in bytes |
| rsp_payload | output | 64 | Response payload, little-endian |
| policy_chg | output | 1 | One-cycle pulse on an accepted load |

## Verification
The bench checks a read placed on the cycle right after a load, which must show zero elapsed time. A design that counts the load edge itself would be off by one step there. The bench loads a value near 2^64 and reads it back; a design with a narrow or saturating adder would fail to wrap. Rejected loads with a short length, and unknown command codes, are placed between a load and a read. A design that stored their payload or restarted the counter would return a wrong time. Reads before any load and right after a mid-run reset must return zero rather than a stale sum.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
   localparam logic [7:0] TS_CMDSET = 8'h03;
   localparam logic [7:0] TS_OP_GET = 8'h00;
   localparam logic [7:0] TS_OP_SET = 8'h01;

   localparam int RC_OK      = 'h00;
   localparam int RC_INVALID = 'h02;
   localparam int RC_UNSUP   = 'h15;

   typedef enum logic [2:0] {
      K_IDLE   = 3'd0,
      K_GET    = 3'd1,
      K_SET    = 3'd2,
      K_SETLEN = 3'd3,
      K_UNSUP  = 3'd4
   } ts_kind_e;
endpackage

// File: rtl/tstamp_decode.sv
module tstamp_decode
   import tstamp_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int TS_BYTES = 8
) (
   input  logic             valid,
   input  logic [7:0]       cset,
   input  logic [7:0]       op,
   input  logic [LEN_W-1:0] len,
   output ts_kind_e         kind
);
   localparam logic [LEN_W-1:0] SET_LEN = LEN_W'(TS_BYTES);

   always_comb begin
      kind = K_IDLE;
      if (valid) begin
         if (cset != TS_CMDSET)   kind = K_UNSUP;
         else if (op == TS_OP_GET) kind = K_GET;
         else if (op == TS_OP_SET) kind = (len == SET_LEN) ? K_SET : K_SETLEN;
         else                      kind = K_UNSUP;
      end
   end
endmodule

// File: rtl/tstamp_elapsed.sv
module tstamp_elapsed #(
   parameter int W       = 64,
   parameter int STEP_NS = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] STEP = W'(STEP_NS);
   logic [W-1:0] nxt;

   generate
      if (STEP_NS == 1) begin : g_unit
         assign nxt = cnt + 1'b1;
      end else begin : g_step
         assign nxt = cnt + STEP;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else            cnt <= nxt;
   end

   // R9: a load restarts the count
   a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt == '0);
   // R5: advance by the step, wrapping modulo 2^W
   a_r5_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> cnt == $past(cnt) + STEP);
endmodule

// File: rtl/tstamp_resp.sv
module tstamp_resp
   import tstamp_pkg::*;
#(
   parameter int TS_W   = 64,
   parameter int LEN_W  = 16,
   parameter int CODE_W = 16
) (
   input  ts_kind_e          kind,
   input  logic              armed,
   input  logic [TS_W-1:0]   host,
   input  logic [TS_W-1:0]   elapsed,
   output logic [CODE_W-1:0] code,
   output logic [LEN_W-1:0]  len,
   output logic [TS_W-1:0]   data,
   output logic              pol
);
   localparam logic [LEN_W-1:0] GET_LEN = LEN_W'(TS_W / 8);
   logic [TS_W-1:0] now;

   assign now = host + elapsed;

   always_comb begin
      code = CODE_W'(RC_OK);
      len  = '0;
      data = '0;
      pol  = 1'b0;
      unique case (kind)
         K_GET: begin
            len  = GET_LEN;
            data = armed ? now : '0;
         end
         K_SET:    pol  = 1'b1;
         K_SETLEN: code = CODE_W'(RC_INVALID);
         K_UNSUP:  code = CODE_W'(RC_UNSUP);
         default: ;
      endcase
   end
endmodule

// File: rtl/tstamp_unit.sv
module tstamp_unit
   import tstamp_pkg::*;
#(
   parameter int TS_W    = 64,
   parameter int LEN_W   = 16,
   parameter int CODE_W  = 16,
   parameter int STEP_NS = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_set,
   input  logic [7:0]        cmd_op,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic [TS_W-1:0]   cmd_payload,
   output logic              rsp_valid,
   output logic [CODE_W-1:0] rsp_code,
   output logic [LEN_W-1:0]  rsp_len,
   output logic [TS_W-1:0]   rsp_payload,
   output logic              policy_chg
);
   localparam int TS_BYTES = TS_W / 8;

   generate
      if (TS_W % 8 != 0 || TS_W < 8) begin : g_bad_w
         $error("TS_W must be a positive multiple of 8");
      end
      if (STEP_NS < 1) begin : g_bad_step
         $error("STEP_NS must be at least 1");
      end
      if (CODE_W < 8 || LEN_W < 4) begin : g_bad_fields
         $error("CODE_W or LEN_W too narrow");
      end
   endgenerate

   ts_kind_e          kind;
   logic [TS_W-1:0]   host_q, elapsed;
   logic              armed_q;
   logic [CODE_W-1:0] c_code;
   logic [LEN_W-1:0]  c_len;
   logic [TS_W-1:0]   c_data;
   logic              c_pol;

   tstamp_decode #(.LEN_W(LEN_W), .TS_BYTES(TS_BYTES)) u_dec (
      .valid(cmd_valid), .cset(cmd_set), .op(cmd_op), .len(cmd_len), .kind(kind));

   tstamp_elapsed #(.W(TS_W), .STEP_NS(STEP_NS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(kind == K_SET), .cnt(elapsed));

   tstamp_resp #(.TS_W(TS_W), .LEN_W(LEN_W), .CODE_W(CODE_W)) u_rsp (
      .kind(kind), .armed(armed_q), .host(host_q), .elapsed(elapsed),
      .code(c_code), .len(c_len), .data(c_data), .pol(c_pol));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_q      <= '0;
         armed_q     <= 1'b0;
         rsp_valid   <= 1'b0;
         rsp_code    <= '0;
         rsp_len     <= '0;
         rsp_payload <= '0;
         policy_chg  <= 1'b0;
      end else begin
         rsp_valid  <= cmd_valid;
         policy_chg <= c_pol;
         if (cmd_valid) begin
            rsp_code    <= c_code;
            rsp_len     <= c_len;
            rsp_payload <= c_data;
         end
         if (kind == K_SET) begin
            host_q  <= cmd_payload;
            armed_q <= 1'b1;
         end
      end
   end

   // R2: one response per strobe, one cycle later
   a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid && !policy_chg);
   // R3: policy pulse only with a successful empty response
   a_r3_policy_ok: assert property (@(posedge clk) disable iff (!rst_n)
      policy_chg |-> rsp_valid && rsp_code == CODE_W'(RC_OK) && rsp_len == '0);
   a_r3_load_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_SET) |=> armed_q && host_q == $past(cmd_payload));
   // R1: read before any load gives zero
   a_r1_unarmed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_GET && !armed_q) |=> rsp_payload == '0);
   // R6: unsupported commands leave state alone
   a_r6_unsup_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_UNSUP) |=> $stable(host_q) && $stable(armed_q) && !policy_chg);
   // R7: bad-length loads leave state alone
   a_r7_badlen_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_SETLEN) |=> $stable(host_q) && $stable(armed_q)
                             && rsp_code == CODE_W'(RC_INVALID));
endmodule

// File: tb/test_tstamp_unit.sv
module test_tstamp_unit;
   localparam int STEP = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_set = '0, cmd_op = '0;
   logic [15:0] cmd_len = '0;
   logic [63:0] cmd_payload = '0;
   logic        rsp_valid, policy_chg;
   logic [15:0] rsp_code, rsp_len;
   logic [63:0] rsp_payload;

   always #10 clk = ~clk;

   tstamp_unit #(.STEP_NS(STEP)) i_tstamp_unit (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
      .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_payload(cmd_payload),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_len(rsp_len),
      .rsp_payload(rsp_payload), .policy_chg(policy_chg));

   int   n_run = 0, n_fail = 0;
   int   cyc = 0;
   bit   done = 1'b0;
   always @(posedge clk) cyc <= cyc + 1;

   // bench model
   logic [63:0] m_host = '0;
   int          m_edge = 0;
   bit          m_armed = 1'b0;

   typedef struct packed {
      logic [3:0]  gap;
      logic [7:0]  cset;
      logic [7:0]  op;
      logic [15:0] len;
      logic [63:0] pay;
      logic [15:0] code;
      logic [15:0] olen;
      logic [3:0]  tag;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 8'h03, 8'h01, 16'd8, 64'h0123_4567_89AB_CDEF, 16'h00, 16'd0, 4'd3},
      '{4'd0, 8'h03, 8'h00, 16'd0, 64'h0,                   16'h00, 16'd8, 4'd4},
      '{4'd3, 8'h03, 8'h00, 16'd0, 64'h0,                   16'h00, 16'd8, 4'd4},
      '{4'd0, 8'h03, 8'h02, 16'd8, 64'hDEAD_BEEF_0000_0001, 16'h15, 16'd0, 4'd6},
      '{4'd0, 8'h04, 8'h01, 16'd8, 64'hDEAD_BEEF_0000_0002, 16'h15, 16'd0, 4'd6},
      '{4'd1, 8'h00, 8'h00, 16'd0, 64'h0,                   16'h15, 16'd0, 4'd6},
      '{4'd0, 8'h03, 8'h01, 16'd4, 64'h5555_5555_5555_5555, 16'h02, 16'd0, 4'd7},
      '{4'd1, 8'h03, 8'h00, 16'd8, 64'hAAAA_AAAA_AAAA_AAAA, 16'h00, 16'd8, 4'd8},
      '{4'd0, 8'h03, 8'h01, 16'd8, 64'hFFFF_FFFF_FFFF_FFF0, 16'h00, 16'd0, 4'd3},
      '{4'd1, 8'h03, 8'h00, 16'd0, 64'h0,                   16'h00, 16'd8, 4'd5},
      '{4'd0, 8'h03, 8'h01, 16'd8, 64'h0000_0000_0000_0010, 16'h00, 16'd0, 4'd9},
      '{4'd5, 8'h03, 8'h00, 16'd0, 64'h0,                   16'h00, 16'd8, 4'd9}
   };

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic issue(input int gap, input logic [7:0] s, input logic [7:0] o,
                        input logic [15:0] l, input logic [63:0] p);
      for (int i = 0; i < gap; i++) @(negedge clk);
      cmd_valid = 1'b1; cmd_set = s; cmd_op = o; cmd_len = l; cmd_payload = p;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   function automatic logic [63:0] model_read(input int edge_now);
      if (!m_armed) return 64'h0;
      return m_host + 64'(STEP) * 64'(edge_now - m_edge - 1);
   endfunction

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      string tag;
      logic [63:0] exp_d;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "rsp_valid at reset", 64'(rsp_valid), 64'h0);
      check("R1", "policy_chg at reset", 64'(policy_chg), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      issue(0, 8'h03, 8'h00, 16'd0, 64'h0);
      check("R1", "unarmed read code", 64'(rsp_code), 64'h0);
      check("R1", "unarmed read len", 64'(rsp_len), 64'd8);
      check("R1", "unarmed read payload", rsp_payload, 64'h0);
      @(negedge clk);
      check("R2", "idle rsp_valid", 64'(rsp_valid), 64'h0);

      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         case (t.tag)
            4'd3: tag = "R3";
            4'd4: tag = "R4";
            4'd5: tag = "R5";
            4'd6: tag = "R6";
            4'd7: tag = "R7";
            4'd8: tag = "R8";
            default: tag = "R9";
         endcase
         issue(int'(t.gap), t.cset, t.op, t.len, t.pay);
         exp_d = 64'h0;
         if (t.cset == 8'h03 && t.op == 8'h00) exp_d = model_read(cyc);
         check("R2", "rsp_valid", 64'(rsp_valid), 64'h1);
         check(tag, "code", 64'(rsp_code), 64'(t.code));
         check(tag, "len", 64'(rsp_len), 64'(t.olen));
         check(tag, "payload", rsp_payload, exp_d);
         check(tag, "policy_chg", 64'(policy_chg),
               (t.cset == 8'h03 && t.op == 8'h01 && t.code == 16'h0) ? 64'h1 : 64'h0);
         if (t.cset == 8'h03 && t.op == 8'h01 && t.code == 16'h0) begin
            m_host = t.pay; m_edge = cyc; m_armed = 1'b1;
         end
      end

      // R3: policy pulse lasts a single cycle
      issue(0, 8'h03, 8'h01, 16'd8, 64'h0000_0100_0000_0000);
      m_host = 64'h0000_0100_0000_0000; m_edge = cyc;
      check("R3", "policy pulse high", 64'(policy_chg), 64'h1);
      @(negedge clk);
      check("R3", "policy pulse ends", 64'(policy_chg), 64'h0);
      // R4: read after a longer wait
      issue(7, 8'h03, 8'h00, 16'd0, 64'h0);
      check("R4", "long wait payload", rsp_payload, model_read(cyc));

      // R1: a mid-run reset drops the loaded time
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'h0);
      rst_n = 1'b1;
      m_armed = 1'b0;
      @(negedge clk);
      issue(2, 8'h03, 8'h00, 16'd0, 64'h0);
      check("R1", "read after reset", rsp_payload, 64'h0);
      check("R1", "len after reset", 64'(rsp_len), 64'd8);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule